// File: doc/BRIEF.md
# Multi-Master I2C Clock Line Synchronizer

This block produces the SCL clock for one I2C master that shares an open-drain clock line with other masters. The line is a wired-AND: any device that pulls it low holds it low for everyone. The block never drives the line high. It asserts a drive-low enable while it holds SCL down and releases the line otherwise. It reads the real line level back through a synchronizer, and its phase counters follow what the line actually does.

Two count inputs set the block's own low and high phase lengths in system clocks. When the block is the only device on the line, the line follows those counts. A slower device stretches the low phase: the block releases, raises a waiting flag, and only starts its high count once the line really rises. A faster device cuts the high phase short: the block sees the line fall, joins in, and times its own low phase from that fall. All masters therefore share one clock. Its low phase is the longest low among them and its high phase is the shortest high.

A one-cycle strobe marks every synchronized rising edge of SCL for the data path. Dropping the enable input releases the line in the same cycle and clears the phase state.

Top module: `scl_sync_gen`

## Requirements
- R1: Out of reset, `scl_drive_low`, `wait_high` and `sample_stb` are all 0.
- R2: With no other device on the line, each low phase of SCL lasts exactly `low_count` system clocks, for any `low_count` of 2 or more.
- R3: With no other device on the line, each high phase of SCL lasts max(`high_count`, SYNC_STAGES+2) system clocks. With the default of 2 synchronizer stages, this is max(`high_count`, 4). The synchronizer and decision latency is subtracted from the high count.
- R4: When another device holds SCL low past this block's own low count, the block keeps the line released and asserts `wait_high` while the line stays low. The following high phase is `high_count` clocks long, measured from the moment the line rises.
- R5: When another device pulls SCL low during this block's high phase, the high phase ends at that fall. The block then drives low, and the low phase measured from that fall is `low_count` clocks, provided `low_count` exceeds the latency and the other device lets go earlier.
- R6: `sample_stb` is high for exactly one clock per SCL rising edge. It falls in the third clock of the high phase (index 2, counting from 0), which reflects the two-stage synchronizer. It is never high during a low phase.
- R7: While `enable` is 0, `scl_drive_low` is 0 in that very cycle, and `wait_high` and `sample_stb` stay 0. After `enable` returns to 1, the first low phase is a full `low_count` long.
- R8: `wait_high` is never followed directly by the block driving the line low. The block always passes through a counted high phase first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the clock generator; 0 releases the line and clears the phase state |
| low_count | input | CNT_W | Own low phase length in clocks (at least 2) |
| high_count | input | CNT_W | Own high phase length in clocks (at least 2) |
| scl_in | input | 1 | Raw level of the shared SCL line |
| scl_drive_low | output | 1 | 1 = pull SCL low (open-drain enable) |
| wait_high | output | 1 | Line released by this block but still seen low |
| sample_stb | output | 1 | One-cycle pulse per synchronized SCL rising edge |

## Verification
The assertions take for granted that `low_count` and `high_count` are both at least 2 whenever `enable` is high. One property checks this input rule directly. The stimulus changes the counts only while the block is free-running, and it skips two full periods before measuring. Another master is modelled in the bench as a second pull-down on the same wired-AND line. The bench only ever changes that pull-down on the falling clock edge, so every line transition the block sees is clean and one clock long.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,   // disabled, line released
      PH_WAIT = 2'd1,   // released, waiting for the line to read high
      PH_HIGH = 2'd2,   // released, counting own high phase
      PH_LOW  = 2'd3    // driving low, counting own low phase
   } phase_e;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("scl_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   // the idle bus is high, so the chain resets to ones
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;

   assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (clr)          cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - ONE;
   end

   assign done = (cnt == '0);

   // a phase of N counts lasts exactly N clocks (R2, R3)
   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
   import scl_sync_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int LAT   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             bus_lvl,
   input  logic             tmr_done,
   input  logic [CNT_W-1:0] low_count,
   input  logic [CNT_W-1:0] high_count,
   output phase_e           phase,
   output logic             tmr_clr,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val
);
   if ((2 ** CNT_W) <= LAT + 1) begin : g_bad_width
      $error("scl_phase_ctrl: CNT_W too narrow for the line latency");
   end

   localparam logic [CNT_W-1:0] LAT_V = CNT_W'(LAT);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);

   // remaining count once the line latency has already elapsed
   function automatic logic [CNT_W-1:0] after_lat(input logic [CNT_W-1:0] x);
      return (x > LAT_V) ? (x - LAT_V - ONE) : '0;
   endfunction

   phase_e nxt;

   always_comb begin
      nxt      = phase;
      tmr_clr  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (!enable) begin
         nxt     = PH_IDLE;
         tmr_clr = 1'b1;
      end else begin
         unique case (phase)
            PH_IDLE: nxt = PH_WAIT;
            PH_WAIT: begin
               if (bus_lvl) begin
                  nxt      = PH_HIGH;
                  tmr_load = 1'b1;
                  tmr_val  = after_lat(high_count);
               end
            end
            PH_HIGH: begin
               if (!bus_lvl) begin
                  // another device ended the high phase
                  nxt      = PH_LOW;
                  tmr_load = 1'b1;
                  tmr_val  = after_lat(low_count);
               end else if (tmr_done) begin
                  nxt      = PH_LOW;
                  tmr_load = 1'b1;
                  tmr_val  = low_count - ONE;
               end
            end
            PH_LOW: begin
               if (tmr_done) nxt = PH_WAIT;
            end
            default: nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= nxt;
   end

   assert_off_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (phase == PH_IDLE));

   assert_wait_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && enable) |=> (phase != PH_LOW));

   assert_cut_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HIGH && enable && !bus_lvl) |=> (phase == PH_LOW));

   assert_min_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (low_count >= TWO && high_count >= TWO));

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
   import scl_sync_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] low_count,
   input  logic [CNT_W-1:0] high_count,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             wait_high,
   output logic             sample_stb
);
   // synchronizer stages plus one decision clock
   localparam int LAT = SYNC_STAGES + 1;

   logic             bus_lvl;
   logic             bus_rise;
   logic             tmr_clr;
   logic             tmr_load;
   logic             tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic [CNT_W-1:0] tmr_cnt;
   phase_e           phase;

   scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (scl_in),
      .level (bus_lvl),
      .rise  (bus_rise)
   );

   scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tmr_clr),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt      (tmr_cnt),
      .done     (tmr_done)
   );

   scl_phase_ctrl #(.CNT_W(CNT_W), .LAT(LAT)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .bus_lvl    (bus_lvl),
      .tmr_done   (tmr_done),
      .low_count  (low_count),
      .high_count (high_count),
      .phase      (phase),
      .tmr_clr    (tmr_clr),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val)
   );

   assign scl_drive_low = enable && (phase == PH_LOW);
   assign wait_high     = enable && (phase == PH_WAIT) && !bus_lvl;
   assign sample_stb    = enable && (phase != PH_IDLE) && bus_rise;

   assert_wait_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wait_high |=> !scl_drive_low);

   assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   assert_idle_counter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (tmr_cnt == '0));

endmodule

// File: tb/sim_scl_sync_gen.sv
module sim_scl_sync_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       other_low = 1'b0;
   logic [7:0] low_count = 8'd5;
   logic [7:0] high_count = 8'd6;
   logic       drv;
   logic       wh;
   logic       stb;
   wire        scl_bus = ~(drv | other_low);

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scl_sync_gen u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .low_count     (low_count),
      .high_count    (high_count),
      .scl_in        (scl_bus),
      .scl_drive_low (drv),
      .wait_high     (wh),
      .sample_stb    (stb)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles >= WATCHDOG && !finished) begin
         n_fail++;
         $display("FAIL watchdog (all R) actual=%0d expected<%0d cycles", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   // move to the first sample of the next run at level lvl
   task automatic seek(input logic lvl);
      while (scl_bus == lvl) step();
      while (scl_bus != lvl) step();
   endtask

   // caller stands on sample 0 of a run at lvl; leaves on sample 0 of the next run
   task automatic run_len(input logic lvl, output int len, output int nstb, output int stb_at);
      len = 0; nstb = 0; stb_at = -1;
      while (scl_bus == lvl) begin
         if (stb) begin
            nstb++;
            stb_at = len;
         end
         len++;
         step();
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      enable = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1", "drive_low after reset", int'(drv), 0);
      chk("R1", "wait_high after reset", int'(wh), 0);
      chk("R1", "sample_stb after reset", int'(stb), 0);
      enable = 1'b1;
   endtask

   task automatic t_alone(input int lo, input int hi);
      int len, nstb, at, exp_hi;
      low_count = 8'(lo);
      high_count = 8'(hi);
      exp_hi = (hi > 4) ? hi : 4;
      seek(1'b0);
      seek(1'b0);
      seek(1'b0);
      run_len(1'b0, len, nstb, at);
      chk("R2", $sformatf("alone low phase L=%0d", lo), len, lo);
      chk("R6", "strobes during low phase", nstb, 0);
      run_len(1'b1, len, nstb, at);
      chk("R3", $sformatf("alone high phase H=%0d", hi), len, exp_hi);
      chk("R6", "strobes per high phase", nstb, 1);
      chk("R6", "strobe position in high phase", at, 2);
   endtask

   task automatic t_stretch();
      int lo_len, bad, len, nstb, at;
      low_count = 8'd5;
      high_count = 8'd6;
      seek(1'b0); seek(1'b0);
      seek(1'b0);
      other_low = 1'b1;
      #1;
      lo_len = 1; bad = 0;
      for (int i = 1; i < 15; i++) begin
         step();
         if (scl_bus == 1'b0) lo_len++;
         if (i == 10) begin
            chk("R4", "wait_high during stretched low", int'(wh), 1);
            chk("R4", "own drive released during stretch", int'(drv), 0);
         end
      end
      step();
      other_low = 1'b0;
      #1;
      chk("R4", "stretched low phase length", lo_len, 15);
      run_len(1'b1, len, nstb, at);
      chk("R4", "high phase after stretch", len, 6);
      chk("R6", "strobe position after stretch", at, 2);
   endtask

   task automatic t_cut();
      int len, nstb, at;
      low_count = 8'd5;
      high_count = 8'd8;
      seek(1'b1); seek(1'b1);
      seek(1'b1);
      step(); step(); step();
      other_low = 1'b1;
      #1;
      chk("R5", "line low on early pull", int'(scl_bus), 0);
      chk("R5", "not yet joined at fall", int'(drv), 0);
      step(); step(); step();
      chk("R5", "joined the low phase", int'(drv), 1);
      other_low = 1'b0;
      #1;
      run_len(1'b0, len, nstb, at);
      chk("R5", "low phase timed from external fall", len + 3, 5);
      run_len(1'b1, len, nstb, at);
      chk("R5", "next high phase after cut", len, 8);
   endtask

   task automatic t_enable();
      int bad, len, nstb, at;
      low_count = 8'd4;
      high_count = 8'd5;
      seek(1'b0); seek(1'b0);
      seek(1'b0);
      chk("R7", "driving before disable", int'(drv), 1);
      enable = 1'b0;
      #1;
      chk("R7", "drive released same cycle", int'(drv), 0);
      chk("R7", "line high after disable", int'(scl_bus), 1);
      bad = 0;
      for (int i = 0; i < 8; i++) begin
         step();
         if (drv || wh || stb) bad++;
      end
      chk("R7", "outputs quiet while disabled", bad, 0);
      enable = 1'b1;
      seek(1'b0);
      run_len(1'b0, len, nstb, at);
      chk("R7", "first low after re-enable", len, 4);
      run_len(1'b1, len, nstb, at);
      chk("R7", "first high after re-enable", len, 5);
   endtask

   initial begin
      t_reset();
      t_alone(5, 6);
      t_alone(2, 2);
      t_alone(7, 3);
      t_stretch();
      t_cut();
      t_enable();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule